// File: doc/BRIEF.md
# Interrupt Entry Timing Sequencer

This block reproduces, state by state, how a small RISC core takes an interrupt and enters its service routine. A request arrives with a source class (non-maskable, on-chip peripheral or external pin), a 4-bit priority, a vector number and a flag that says whether the source may start a DMA transfer. When idle, the block takes the request if it is non-maskable or if its priority beats the mask field of the status register. It then spends the judgment states that the source class needs and waits for the core to finish its current sequence.

Exception processing then runs three longword accesses through a memory port with wait states. These are a status-register push, a program-counter push and a vector fetch from the vector table. The sequencer then issues the first fetch of the service routine at the vector address it read. At that point it hands back the new stack pointer and the raised interrupt mask level. A cycle counter records the whole response time so that it can be compared with the timing formula.

Top module: `irq_entry_seq`

## Requirements
- R1: While idle, `req_ack` is high in the same cycle as `req_valid` only when `req_class` is 0 (non-maskable) or `req_prio` is strictly greater than the mask field `cpu_sr[7:4]`. A request that is not taken starts no memory access and no fetch.
- R2: After acceptance, one DMA-judgment state is spent when `req_class` is 2 (external pin). For class 0 or class 1 (peripheral), that state is spent only when `req_dma_cap` is high.
- R3: Priority judgment lasts 3 states for class 2 and 2 states for classes 0 and 1.
- R4: Exception processing begins only after a cycle in which `cpu_done` is high, at or after the last judgment state. Each extra cycle with `cpu_done` low adds one state (X).
- R5: The three accesses are issued in a fixed order. The first is a write of the status register at `cpu_sp`-4. The second is a write of the program counter at `cpu_sp`-8. The third is a read at `vbr` + 4×vector.
- R6: Each access keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until a cycle with `mem_ready` high. It lasts 1 state plus one state per cycle with `mem_ready` low.
- R7: The response time runs from the first state after acceptance to the fetch cycle, both counted. It equals d + j + X + 5 + m1 + m2 + m3 and is shown on `lat_count`. This gives 10 states (classes 0/1, no DMA) or 12 states (class 2) with single-state accesses and X = 0.
- R8: `fetch_req` is high for exactly one cycle. In that cycle `fetch_addr` equals the word returned by the vector read, and `sp_new` equals `cpu_sp`-8.
- R9: In the fetch cycle, `sr_mask_we` is high. `sr_mask_new` is 15 for class 0 and the accepted priority for the other classes.
- R10: A request presented while a sequence is in progress is not acknowledged.
- R11: After reset the block is idle. `mem_req`, `fetch_req`, `sr_mask_we` are low and `lat_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present, held until acknowledged |
| req_class | input | 2 | 0 non-maskable, 1 peripheral, 2 external pin |
| req_dma_cap | input | 1 | Source may start a DMA transfer |
| req_prio | input | 4 | Request priority |
| req_vec | input | 8 | Vector number |
| req_ack | output | 1 | Request taken this cycle |
| cpu_done | input | 1 | Core has finished its current sequence |
| cpu_sr | input | 32 | Status register, mask in bits 7:4 |
| cpu_pc | input | 32 | Program counter to save |
| cpu_sp | input | 32 | Stack pointer before entry |
| vbr | input | 32 | Vector table base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data |
| fetch_req | output | 1 | First service-routine fetch issued |
| fetch_addr | output | 32 | Service-routine start address |
| sp_new | output | 32 | Stack pointer after the two pushes |
| sr_mask_we | output | 1 | Mask update strobe |
| sr_mask_new | output | 4 | New interrupt mask level |
| lat_count | output | 16 | Response time of the last entry in states |

## Verification
Some properties are checked by the assertions on every cycle. A stalled access must hold its request fields steady. Exception processing may start only after `cpu_done`. The mask only ever rises to the accepted level. A fetch never lasts two cycles, and no two acknowledges come back to back. The bench scenarios are the only place where the exact state counts appear. They cover the DMA judgment per class, the 2/3-state judgment, the X and wait-state contributions to the total, the order and addresses of the three accesses, and the rejection of a request whose priority equals the mask.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int VEC_W    = 8,
  parameter int MASK_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_class,
  input  logic              req_dma_cap,
  input  logic [3:0]        req_prio,
  input  logic [VEC_W-1:0]  req_vec,
  output logic              req_ack,
  input  logic              cpu_done,
  input  logic [31:0]       cpu_sr,
  input  logic [31:0]       cpu_pc,
  input  logic [ADDR_W-1:0] cpu_sp,
  input  logic [ADDR_W-1:0] vbr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic              fetch_req,
  output logic [31:0]       fetch_addr,
  output logic [ADDR_W-1:0] sp_new,
  output logic              sr_mask_we,
  output logic [3:0]        sr_mask_new,
  output logic [CNT_W-1:0]  lat_count
);

  localparam logic [1:0] CLS_NMI = 2'd0;
  localparam logic [1:0] CLS_PIN = 2'd2;
  localparam logic [ADDR_W-1:0] WORD = ADDR_W'(4);

  typedef enum logic [3:0] {
    S_IDLE, S_DMA, S_JUDGE, S_WAIT, S_PRE, S_SRW, S_PCW, S_VRD, S_POST, S_FETCH
  } st_t;

  st_t               state;
  logic [1:0]        ph;
  logic              pin_r;
  logic [3:0]        lvl_r;
  logic [VEC_W-1:0]  vec_r;
  logic [31:0]       sr_r, pc_r, vec_data_r;
  logic [ADDR_W-1:0] sp_r;
  logic [CNT_W-1:0]  lat_r;

  wire [3:0] cur_mask   = cpu_sr[MASK_LSB +: 4];
  wire       accept     = (state == S_IDLE) && req_valid &&
                          (req_class == CLS_NMI || req_prio > cur_mask);
  wire       judge_last = (state == S_JUDGE) && (ph == (pin_r ? 2'd2 : 2'd1));
  wire       go_exc     = (judge_last || state == S_WAIT) && cpu_done;

  assign req_ack     = accept;
  assign mem_req     = (state == S_SRW) || (state == S_PCW) || (state == S_VRD);
  assign mem_we      = (state == S_SRW) || (state == S_PCW);
  assign mem_addr    = (state == S_SRW) ? sp_r - WORD :
                       (state == S_PCW) ? sp_r - 2 * WORD :
                       vbr + ADDR_W'({vec_r, 2'b00});
  assign mem_wdata   = (state == S_SRW) ? sr_r : (state == S_PCW) ? pc_r : 32'h0;
  assign fetch_req   = (state == S_FETCH);
  assign fetch_addr  = vec_data_r;
  assign sp_new      = sp_r - 2 * WORD;
  assign sr_mask_we  = (state == S_FETCH);
  assign sr_mask_new = lvl_r;
  assign lat_count   = lat_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      ph         <= '0;
      pin_r      <= 1'b0;
      lvl_r      <= '0;
      vec_r      <= '0;
      sr_r       <= '0;
      pc_r       <= '0;
      sp_r       <= '0;
      vec_data_r <= '0;
      lat_r      <= '0;
    end else begin
      if (state != S_IDLE && state != S_FETCH && lat_r != '1)
        lat_r <= lat_r + 1'b1;
      if (go_exc) begin
        sr_r  <= cpu_sr;
        pc_r  <= cpu_pc;
        sp_r  <= cpu_sp;
        ph    <= '0;
        state <= S_PRE;
      end
      case (state)
        S_IDLE: if (accept) begin
          pin_r <= (req_class == CLS_PIN);
          lvl_r <= (req_class == CLS_NMI) ? 4'd15 : req_prio;
          vec_r <= req_vec;
          lat_r <= CNT_W'(1);
          ph    <= '0;
          state <= (req_class == CLS_PIN || req_dma_cap) ? S_DMA : S_JUDGE;
        end
        S_DMA: begin
          ph    <= '0;
          state <= S_JUDGE;
        end
        S_JUDGE: if (!go_exc) begin
          ph <= ph + 1'b1;
          if (judge_last) state <= S_WAIT;
        end
        S_PRE: begin
          ph <= ph + 1'b1;
          if (ph == 2'd1) state <= S_SRW;
        end
        S_SRW: if (mem_ready) state <= S_PCW;
        S_PCW: if (mem_ready) state <= S_VRD;
        S_VRD: if (mem_ready) begin
          vec_data_r <= mem_rdata;
          ph         <= '0;
          state      <= S_POST;
        end
        S_POST: begin
          ph <= ph + 1'b1;
          if (ph == 2'd1) state <= S_FETCH;
        end
        S_FETCH: state <= S_IDLE;
        default: ;
      endcase
    end
  end

  assert_access_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_exc_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PRE && ph == 2'd0) |-> $past(cpu_done));

  assert_mask_rises_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sr_mask_we |-> (lvl_r == 4'd15 || lvl_r > sr_r[MASK_LSB +: 4]));

  assert_fetch_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> (!fetch_req && !mem_req));

  assert_min_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (lat_count >= CNT_W'(10)));

  assert_no_ack_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

endmodule

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_dma_cap = 0, cpu_done = 0, mem_ready = 0;
  logic [1:0]  req_class = 0;
  logic [3:0]  req_prio = 0;
  logic [7:0]  req_vec = 0;
  logic [31:0] cpu_sr = 0, cpu_pc = 0, cpu_sp = 0, vbr = 0;
  logic        req_ack, mem_req, mem_we, fetch_req, sr_mask_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, fetch_addr, sp_new;
  logic [3:0]  sr_mask_new;
  logic [15:0] lat_count;

  localparam logic [31:0] RD_XOR = 32'hA5A5_0000;
  assign mem_rdata = mem_addr ^ RD_XOR;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .req_dma_cap(req_dma_cap), .req_prio(req_prio), .req_vec(req_vec), .req_ack(req_ack),
    .cpu_done(cpu_done), .cpu_sr(cpu_sr), .cpu_pc(cpu_pc), .cpu_sp(cpu_sp), .vbr(vbr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .sp_new(sp_new), .sr_mask_we(sr_mask_we),
    .sr_mask_new(sr_mask_new), .lat_count(lat_count)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  int waits = 0, acc = 0, acc_n = 0;
  logic [31:0] log_addr [0:3];
  logic [31:0] log_data [0:3];
  logic        log_we   [0:3];

  always @(negedge clk) begin
    if (!mem_req) begin
      mem_ready = 1'b0;
      acc = 0;
    end else if (acc == waits) begin
      mem_ready = 1'b1;
      acc = 0;
      if (acc_n < 4) begin
        log_addr[acc_n] = mem_addr;
        log_data[acc_n] = mem_wdata;
        log_we[acc_n]   = mem_we;
      end
      acc_n++;
    end else begin
      mem_ready = 1'b0;
      acc++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_entry(input logic [1:0] cls, input logic dma, input logic [3:0] prio,
                           input logic [3:0] mask, input logic [7:0] vec, input int x,
                           input int w, input bit poke);
    int d, j, expv, idx, got;
    bit seen;
    logic [31:0] sp0, pc0, sr0;
    d = (cls == 2'd2 || dma) ? 1 : 0;
    j = (cls == 2'd2) ? 3 : 2;
    expv = d + j + x + 5 + 3 * (w + 1);
    sp0 = 32'h0000_8000 + 32'(vec) * 16;
    pc0 = 32'h1000_0000 | 32'(prio);
    sr0 = {24'h0, mask, 4'h3};
    @(negedge clk);
    acc_n = 0; waits = w;
    cpu_sr = sr0; cpu_pc = pc0; cpu_sp = sp0; vbr = 32'h0002_0000;
    req_class = cls; req_dma_cap = dma; req_prio = prio; req_vec = vec;
    req_valid = 1; cpu_done = 0;
    #1 chk("R1 ack", {31'h0, req_ack}, 32'h1);
    @(negedge clk);
    req_valid = 0; idx = 1; seen = 0; got = 0;
    while (!seen && idx < 200) begin
      cpu_done = (idx >= d + j + x);
      if (poke && idx == 3) begin req_valid = 1; req_class = 2'd0; end
      #1;
      if (poke && idx == 3) begin
        chk("R10 ack while busy", {31'h0, req_ack}, 32'h0);
        req_valid = 0; req_class = cls;
      end
      if (fetch_req) begin
        seen = 1; got = idx;
        chk("R8 fetch_addr", fetch_addr, (32'h0002_0000 + 32'(vec) * 4) ^ RD_XOR);
        chk("R8 sp_new", sp_new, sp0 - 8);
        chk("R9 mask_we", {31'h0, sr_mask_we}, 32'h1);
        chk("R9 mask_new", {28'h0, sr_mask_new}, (cls == 2'd0) ? 32'd15 : {28'h0, prio});
        chk("R7 lat_count", {16'h0, lat_count}, expv);
      end else begin
        @(negedge clk);
        idx++;
      end
    end
    chk("R7 R2 R3 R4 R6 measured latency", got, expv);
    chk("R5 access count", acc_n, 3);
    chk("R5 sr push addr", log_addr[0], sp0 - 4);
    chk("R5 sr push data", log_data[0], sr0);
    chk("R5 sr push we", {31'h0, log_we[0]}, 32'h1);
    chk("R5 pc push addr", log_addr[1], sp0 - 8);
    chk("R5 pc push data", log_data[1], pc0);
    chk("R5 pc push we", {31'h0, log_we[1]}, 32'h1);
    chk("R5 vector addr", log_addr[2], 32'h0002_0000 + 32'(vec) * 4);
    chk("R5 vector read", {31'h0, log_we[2]}, 32'h0);
    @(negedge clk);
    chk("R8 fetch one cycle", {31'h0, fetch_req}, 32'h0);
    cpu_done = 0;
  endtask

  task automatic test_reset;
    #1;
    chk("R11 mem_req", {31'h0, mem_req}, 32'h0);
    chk("R11 fetch_req", {31'h0, fetch_req}, 32'h0);
    chk("R11 mask_we", {31'h0, sr_mask_we}, 32'h0);
    chk("R11 lat_count", {16'h0, lat_count}, 32'h0);
  endtask

  task automatic test_nmi_min;      run_entry(2'd0, 1'b0, 4'd0, 4'd15, 8'd11, 0, 0, 0); endtask
  task automatic test_pin_min;      run_entry(2'd2, 1'b0, 4'd5, 4'd2,  8'd64, 0, 0, 0); endtask
  task automatic test_periph_dma;   run_entry(2'd1, 1'b1, 4'd9, 4'd8,  8'd90, 0, 0, 0); endtask
  task automatic test_periph_slow;  run_entry(2'd1, 1'b0, 4'd3, 4'd0,  8'd120, 3, 2, 0); endtask
  task automatic test_pin_waits;    run_entry(2'd2, 1'b0, 4'd14, 4'd13, 8'd200, 1, 1, 0); endtask
  task automatic test_busy_ignored; run_entry(2'd1, 1'b0, 4'd6, 4'd1,  8'd33, 2, 0, 1); endtask

  task automatic test_reject;
    logic [15:0] lat0;
    int bad;
    bad = 0;
    @(negedge clk);
    lat0 = lat_count;
    cpu_sr = {24'h0, 4'd7, 4'h0};
    req_class = 2'd2; req_prio = 4'd7; req_dma_cap = 0; req_vec = 8'd5; req_valid = 1;
    #1 chk("R1 equal prio rejected", {31'h0, req_ack}, 32'h0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      if (mem_req || fetch_req || req_ack) bad++;
    end
    chk("R1 no activity after reject", bad, 0);
    chk("R1 lat unchanged", {16'h0, lat_count}, {16'h0, lat0});
    req_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    test_nmi_min();
    test_pin_min();
    test_periph_dma();
    test_periph_slow();
    test_pin_waits();
    test_reject();
    test_busy_ignored();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule